// File: doc/BRIEF.md
# Flash Access Protection Controller

This controller sits between a flash array and the logic that drives it, and decides which flash operations are allowed in each cycle. It watches four things: a flash write-enable pin qualified by an on-chip-ROM operating mode, the program and erase request bits of a control register, an error-detect input raised by separate checking logic, and the standby events (software standby entry and exit strobes, hardware standby, reset). It drives four permission enables (read, verify-read, program, erase), a sticky error flag and a register-clear level that holds the control and block-select registers at their initial values.

Seven internal states cover the normal read/verify mode, program mode, erase mode, error lock, plain sleep, sleep while locked, and hold after reset or hardware standby. When an error is detected during programming or erasing, the flash enters a lock that keeps reads working but blocks verify, program and erase. Only reset or hardware standby releases that lock. Software standby does not release it. Every input is sampled on the rising clock edge, and the outputs change on that same edge.

Top module: `flash_guard`

## Requirements
- R1: While `rstN` is low (asynchronous) or in the cycle after `hwStandby` is sampled high, all four permissions are 0, `errFlag` is 0 and `regClear` is 1. The first rising edge that samples `hwStandby` low, with reset released, enters the normal mode.
- R2: In the normal mode, `rdEn`, `vfEn`, `prEn` and `erEn` are all 1, and `errFlag` and `regClear` are both 0.
- R3: The write qualifier is `fweIn & romMode`. In the normal mode with the qualifier at 1, `progBit`=1 and `eraseBit`=0 enter program mode, and `eraseBit`=1 and `progBit`=0 enter erase mode. With the qualifier at 0, both bits are ignored. Program and erase modes drive the same outputs as the normal mode.
- R4: `errDetect` moves program or erase mode into the error lock on the next edge. In the lock, `rdEn`=1, `vfEn`=`prEn`=`erEn`=0, `errFlag`=1 and `regClear`=0. `errDetect` has no effect in the normal mode.
- R5: `progBit` and `eraseBit` both at 1 with the qualifier at 1, sampled in the normal, program or erase mode, enter the error lock.
- R6: Program or erase mode returns to the normal mode when `progBit` and `eraseBit` are both 0.
- R7: When the qualifier drops to 0 in program or erase mode, the block returns to the normal mode on the next edge, unless an error or a standby entry is sampled in the same cycle.
- R8: The error flag is sticky. Once the block is in the error lock, `progBit`, `eraseBit`, `errDetect`, `fweIn` and `romMode` have no effect. Only reset or hardware standby clears the flag.
- R9: `stbyEnter` in the error lock gives all permissions 0, `regClear`=1 and `errFlag`=1. `stbyExit` from that state returns to the error lock.
- R10: `stbyEnter` in the normal, program or erase mode gives all permissions 0, `errFlag`=0 and `regClear`=1, and `stbyExit` returns to the normal mode. An error, or both request bits with the qualifier at 1, takes priority over `stbyEnter` in the same cycle.
- R11: `hwStandby` has priority over every other input in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwStandby | input | 1 | Hardware standby request, synchronous |
| fweIn | input | 1 | Flash write-enable pin level |
| romMode | input | 1 | Operating mode has on-chip ROM enabled |
| progBit | input | 1 | Program request bit of the control register |
| eraseBit | input | 1 | Erase request bit of the control register |
| errDetect | input | 1 | Error detected by external checking logic |
| stbyEnter | input | 1 | Software standby entry strobe |
| stbyExit | input | 1 | Software standby exit strobe |
| rdEn | output | 1 | Memory read permitted |
| vfEn | output | 1 | Verify-read permitted |
| prEn | output | 1 | Programming permitted |
| erEn | output | 1 | Erasing permitted |
| errFlag | output | 1 | Sticky error flag |
| regClear | output | 1 | Hold control and block-select registers at their initial values |

## Verification
The properties assume that every input is synchronous to `clk` and that `stbyEnter` and `stbyExit` arrive as single-cycle strobes, never in the same cycle. The random stimulus draws the two strobes from one shared choice, so they are mutually exclusive. It keeps hardware standby and errors rare, so that long runs of program, erase and standby states occur. Asynchronous reset is applied only on the falling edge, which keeps it away from the sampling edge.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [2:0] {
    ST_HOLD       = 3'd0,
    ST_READ       = 3'd1,
    ST_PROG       = 3'd2,
    ST_ERASE      = 3'd3,
    ST_LOCK       = 3'd4,
    ST_SLEEP      = 3'd5,
    ST_LOCK_SLEEP = 3'd6
  } guardState_t;

  typedef struct packed {
    logic rd;
    logic vf;
    logic pr;
    logic er;
  } permVec_t;

  typedef struct packed {
    permVec_t perm;
    logic     setErr;
    logic     clrErr;
    logic     clrRegs;
  } guardStrobe_t;

  localparam int PERM_W = $bits(permVec_t);
  localparam permVec_t PERM_ALL  = '{rd: 1'b1, vf: 1'b1, pr: 1'b1, er: 1'b1};
  localparam permVec_t PERM_NONE = '{rd: 1'b0, vf: 1'b0, pr: 1'b0, er: 1'b0};
  localparam permVec_t PERM_READ = '{rd: 1'b1, vf: 1'b0, pr: 1'b0, er: 1'b0};

endpackage

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hwStandby,
  input  logic         wrEnOk,
  input  logic         progReq,
  input  logic         eraseReq,
  input  logic         errDetect,
  input  logic         stbyEnter,
  input  logic         stbyExit,
  output guardStrobe_t strobe
);

  guardState_t stateQ, stateD;
  logic bothReq;
  logic anyReq;

  assign bothReq = wrEnOk && progReq && eraseReq;
  assign anyReq  = progReq || eraseReq;

  always_comb begin
    stateD = stateQ;
    if (hwStandby) begin
      stateD = ST_HOLD;
    end else begin
      unique case (stateQ)
        ST_HOLD: stateD = ST_READ;
        ST_READ: begin
          if (bothReq)                            stateD = ST_LOCK;
          else if (stbyEnter)                     stateD = ST_SLEEP;
          else if (wrEnOk && progReq)             stateD = ST_PROG;
          else if (wrEnOk && eraseReq)            stateD = ST_ERASE;
        end
        ST_PROG, ST_ERASE: begin
          if (errDetect || bothReq)               stateD = ST_LOCK;
          else if (stbyEnter)                     stateD = ST_SLEEP;
          else if (!wrEnOk || !anyReq)            stateD = ST_READ;
        end
        ST_LOCK:       if (stbyEnter) stateD = ST_LOCK_SLEEP;
        ST_SLEEP:      if (stbyExit)  stateD = ST_READ;
        ST_LOCK_SLEEP: if (stbyExit)  stateD = ST_LOCK;
        default:                      stateD = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_HOLD;
    else       stateQ <= stateD;
  end

  // Strobes are derived from the next state so the datapath registers
  // line up with the state register.
  always_comb begin
    strobe         = '0;
    strobe.clrErr  = (stateD == ST_HOLD);
    strobe.setErr  = (stateD == ST_LOCK) || (stateD == ST_LOCK_SLEEP);
    strobe.clrRegs = (stateD == ST_HOLD) || (stateD == ST_SLEEP) ||
                     (stateD == ST_LOCK_SLEEP);
    unique case (stateD)
      ST_READ, ST_PROG, ST_ERASE: strobe.perm = PERM_ALL;
      ST_LOCK:                    strobe.perm = PERM_READ;
      default:                    strobe.perm = PERM_NONE;
    endcase
  end

  assert_leave_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && !hwStandby) |=> (stateQ == ST_READ));

  assert_prog_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_READ && !wrEnOk && !hwStandby && !stbyEnter) |=> (stateQ == ST_READ));

  assert_wr_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_PROG || stateQ == ST_ERASE) && !wrEnOk && !hwStandby &&
     !errDetect && !stbyEnter) |=> (stateQ == ST_READ));

  assert_lock_wake_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LOCK_SLEEP && stbyExit && !hwStandby) |=> (stateQ == ST_LOCK));

  assert_plain_wake_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP && stbyExit && !hwStandby) |=> (stateQ == ST_READ));

endmodule

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  guardStrobe_t strobe,
  output permVec_t     permOut,
  output logic         errOut,
  output logic         clearOut
);

  permVec_t permQ;
  logic     errQ;
  logic     clearQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      permQ  <= PERM_NONE;
      clearQ <= 1'b1;
    end else begin
      permQ  <= strobe.perm;
      clearQ <= strobe.clrRegs;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errQ <= 1'b0;
    else if (strobe.clrErr) errQ <= 1'b0;
    else if (strobe.setErr) errQ <= 1'b1;
  end

  assign permOut  = permQ;
  assign errOut   = errQ;
  assign clearOut = clearQ;

  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !strobe.clrErr) |=> errQ);

  assert_clear_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrErr |=> (!errQ && clearQ));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hwStandby,
  input  logic fweIn,
  input  logic romMode,
  input  logic progBit,
  input  logic eraseBit,
  input  logic errDetect,
  input  logic stbyEnter,
  input  logic stbyExit,
  output logic rdEn,
  output logic vfEn,
  output logic prEn,
  output logic erEn,
  output logic errFlag,
  output logic regClear
);

  guardStrobe_t strobe;
  permVec_t     perm;

  flash_guard_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hwStandby (hwStandby),
    .wrEnOk    (fweIn & romMode),
    .progReq   (progBit),
    .eraseReq  (eraseBit),
    .errDetect (errDetect),
    .stbyEnter (stbyEnter),
    .stbyExit  (stbyExit),
    .strobe    (strobe)
  );

  flash_guard_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .permOut  (perm),
    .errOut   (errFlag),
    .clearOut (regClear)
  );

  assign rdEn = perm.rd;
  assign vfEn = perm.vf;
  assign prEn = perm.pr;
  assign erEn = perm.er;

  assert_normal_perms_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !errFlag) |-> (vfEn && prEn && erEn && !regClear));

  assert_lock_perms_R4: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!vfEn && !prEn && !erEn));

  assert_hw_priority_R11: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> (!rdEn && !vfEn && !prEn && !erEn && !errFlag && regClear));

  assert_lock_stby_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && stbyEnter && !hwStandby) |=> (errFlag && !rdEn && regClear));

endmodule

// File: tb/tb_flash_guard.sv
`timescale 1ns/1ps
module tb_flash_guard;

  localparam real CLK_PERIOD = 20.0;
  localparam int  RAND_STEPS = 4000;

  logic clk = 1'b0;
  logic rstN, hwStandby, fweIn, romMode, progBit, eraseBit, errDetect, stbyEnter, stbyExit;
  logic rdEn, vfEn, prEn, erEn, errFlag, regClear;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  typedef enum int {M_HOLD, M_READ, M_PROG, M_ERASE, M_LOCK, M_SLEEP, M_LSLEEP} mst_t;
  mst_t model;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_guard dut (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .fweIn(fweIn), .romMode(romMode),
    .progBit(progBit), .eraseBit(eraseBit), .errDetect(errDetect),
    .stbyEnter(stbyEnter), .stbyExit(stbyExit),
    .rdEn(rdEn), .vfEn(vfEn), .prEn(prEn), .erEn(erEn),
    .errFlag(errFlag), .regClear(regClear)
  );

  function automatic mst_t refNext(mst_t s, bit hws, bit ok, bit pr, bit er,
                                   bit err, bit sen, bit sex);
    if (hws) return M_HOLD;
    case (s)
      M_HOLD: return M_READ;
      M_READ: begin
        if (ok && pr && er) return M_LOCK;
        if (sen)            return M_SLEEP;
        if (ok && pr)       return M_PROG;
        if (ok && er)       return M_ERASE;
        return M_READ;
      end
      M_PROG, M_ERASE: begin
        if (err || (ok && pr && er)) return M_LOCK;
        if (sen)                     return M_SLEEP;
        if (!ok || (!pr && !er))     return M_READ;
        return s;
      end
      M_LOCK:   return sen ? M_LSLEEP : M_LOCK;
      M_SLEEP:  return sex ? M_READ : M_SLEEP;
      M_LSLEEP: return sex ? M_LOCK : M_LSLEEP;
      default:  return M_HOLD;
    endcase
  endfunction

  // {rd, vf, pr, er, errFlag, regClear}
  function automatic logic [5:0] refOut(mst_t s);
    case (s)
      M_READ, M_PROG, M_ERASE: return 6'b1111_00;
      M_LOCK:                  return 6'b1000_10;
      M_SLEEP:                 return 6'b0000_01;
      M_LSLEEP:                return 6'b0000_11;
      default:                 return 6'b0000_01;
    endcase
  endfunction

  function automatic string stateTag(mst_t s);
    case (s)
      M_HOLD:   return "R11";
      M_READ:   return "R2";
      M_PROG:   return "R3";
      M_ERASE:  return "R3";
      M_LOCK:   return "R4";
      M_SLEEP:  return "R10";
      default:  return "R9";
    endcase
  endfunction

  task automatic check(string tag);
    logic [5:0] act, exp;
    act = {rdEn, vfEn, prEn, erEn, errFlag, regClear};
    exp = refOut(model);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs actual=%b expected=%b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, advance the model, move to the next falling edge and check.
  task automatic step(string tag, bit hws, bit fwe, bit rom, bit pr, bit er,
                      bit err, bit sen, bit sex);
    hwStandby = hws; fweIn = fwe; romMode = rom; progBit = pr; eraseBit = er;
    errDetect = err; stbyEnter = sen; stbyExit = sex;
    model = refNext(model, hws, fwe & rom, pr, er, err, sen, sex);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic asyncReset();
    rstN = 1'b0;
    #1;
    model = M_HOLD;
    check("R1");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; hwStandby = 0; fweIn = 0; romMode = 0; progBit = 0; eraseBit = 0;
    errDetect = 0; stbyEnter = 0; stbyExit = 0;
    model = M_HOLD;
    repeat (3) @(negedge clk);
    check("R1");                        // reset state
    rstN = 1'b1;
    idle("R1");                         // leave hold -> normal
    idle("R2");
    step("R4", 0, 1, 1, 0, 0, 1, 0, 0); // error ignored in normal
    step("R3", 0, 0, 1, 1, 0, 0, 0, 0); // gate closed: stay normal
    step("R3", 0, 1, 1, 0, 0, 1, 0, 0); // proves no program mode
    step("R3", 0, 1, 1, 1, 0, 0, 0, 0); // enter program
    step("R4", 0, 1, 1, 1, 0, 1, 0, 0); // error -> lock
    step("R8", 0, 1, 1, 1, 1, 1, 0, 0); // lock ignores requests
    step("R8", 0, 0, 0, 0, 1, 1, 0, 0);
    step("R8", 0, 1, 1, 0, 0, 0, 0, 1); // exit strobe ignored in lock
    step("R9", 0, 1, 1, 0, 0, 0, 1, 0); // locked sleep
    step("R9", 0, 1, 1, 1, 0, 1, 0, 0); // sleep ignores others
    step("R9", 0, 1, 1, 0, 0, 0, 0, 1); // back to lock
    step("R11", 1, 1, 1, 1, 0, 1, 1, 0);// hardware standby wins
    idle("R1");
    step("R3", 0, 1, 1, 0, 1, 0, 0, 0); // erase
    step("R6", 0, 1, 1, 0, 0, 0, 0, 0); // both bits 0 -> normal
    step("R6", 0, 1, 1, 0, 0, 1, 0, 0); // error ignored: normal
    step("R3", 0, 1, 1, 1, 0, 0, 0, 0);
    step("R7", 0, 1, 0, 1, 0, 0, 0, 0); // rom mode dropped -> normal
    step("R7", 0, 1, 0, 1, 0, 1, 0, 0); // error ignored: normal
    step("R5", 0, 1, 1, 1, 1, 0, 0, 0); // both bits -> lock
    step("R11", 1, 1, 1, 0, 0, 0, 0, 0);
    idle("R1");
    step("R10", 0, 1, 1, 0, 0, 0, 1, 0);// plain sleep
    step("R10", 0, 1, 1, 0, 0, 0, 0, 1);// wake -> normal
    step("R3", 0, 1, 1, 0, 1, 0, 0, 0);
    step("R10", 0, 1, 1, 0, 1, 1, 1, 0);// error beats standby
    step("R11", 1, 0, 0, 0, 0, 0, 0, 0);
    idle("R1");
    step("R3", 0, 1, 1, 1, 0, 0, 0, 0);
    step("R10", 0, 1, 1, 1, 0, 0, 1, 0);// standby from program
    step("R10", 0, 1, 1, 0, 0, 0, 0, 1);

    for (int i = 0; i < RAND_STEPS; i++) begin
      bit hws, fwe, rom, pr, er, err, sen, sex;
      int sel;
      hws = ($urandom_range(0, 59) == 0);
      fwe = ($urandom_range(0, 7) != 0);
      rom = ($urandom_range(0, 9) != 0);
      pr  = ($urandom_range(0, 2) == 0);
      er  = ($urandom_range(0, 2) == 0);
      err = ($urandom_range(0, 14) == 0);
      sel = $urandom_range(0, 19);
      sen = (sel == 0);
      sex = (sel >= 15);
      step(stateTag(refNext(model, hws, fwe & rom, pr, er, err, sen, sex)),
           hws, fwe, rom, pr, er, err, sen, sex);
      if (i == RAND_STEPS / 2) asyncReset();
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule